// File: doc/BRIEF.md
# Dual-Latch Synchronized Timestamp Counter

This block keeps a free-running timestamp for one of two cooperating acquisition systems. A prescaler divides the fast block clock into a reference tick. The timestamp counter advances by one on each tick and wraps when it overflows. Two independent capture registers hold the count. One is loaded when this system's own trigger arrives. The other is loaded when the partner system's trigger arrives. The difference between the two stored values gives the time between the two systems' events.

The counter can be cleared in two ways. The first is an external reset input, which can be disabled by a select input so that the other side has control. The second is a synchronous run-start command. On run start the local counter is cleared, and on the same clock edge a reset pulse of fixed length begins on an output, so the partner's counter is zeroed at the same time. The block also drives a square wave at twice the reference tick rate, which the partner system uses as its clock reference.

Each capture register has a valid flag and an overrun flag. A read strobe clears both flags. All asynchronous inputs pass through synchronizer flops and act only on their rising edge.

Top module: `tsc_sync_core`

## Requirements
- R1: The counter is TS_W bits wide and is zero after a clear. It increments by one once every REF_DIV clock cycles, so m cycles after the clear edge it reads floor(m/REF_DIV) modulo 2^TS_W. It wraps from all-ones to zero.
- R2: The trigger inputs and the external reset input pass through SYNC_STAGES flops. Each acts only on a rising edge: an input that goes high before clock edge e takes effect at edge e+SYNC_STAGES. An input held high acts once, and a falling edge does nothing.
- R3: A local trigger loads the local capture register with the counter value from just before the capture edge. The register holds that value until the next local capture.
- R4: A partner trigger loads a separate capture register in the same way. Neither trigger disturbs the other register or its flags.
- R5: A capture sets that register's valid flag, and a read strobe clears it. If a capture and a read happen in the same cycle, valid stays set and overrun is cleared.
- R6: A capture while valid is set and no read is present sets the overrun flag and replaces the data with the newer value. Overrun is never set while valid is clear. A read clears it.
- R7: When ext_rst_en_i is 1, a rising edge on ts_rst_i clears the counter, the prescaler phase and the square wave. When ext_rst_en_i is 0, the counter keeps counting as if no edge had occurred. The external reset never drives peer_rst_o.
- R8: On a clock edge where run_start_i is 1, the counter clears and peer_rst_o rises. peer_rst_o stays high for exactly RST_CYCLES cycles.
- R9: clk2x_o is 0 right after a clear and toggles every REF_DIV/4 cycles, which gives a period of REF_DIV/2 cycles (twice the tick rate). It is high during the cycle in which the counter steps.
- R10: While rst_n is low, the counter, both capture registers, all flags, peer_rst_o and clk2x_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_local_i | input | 1 | This system's trigger (asynchronous) |
| trig_peer_i | input | 1 | Partner system's trigger (asynchronous) |
| ts_rst_i | input | 1 | External counter reset (asynchronous) |
| ext_rst_en_i | input | 1 | 1: external reset clears the counter; 0: ignored |
| run_start_i | input | 1 | Synchronous run-start strobe |
| rd_local_i | input | 1 | Read strobe for the local capture register |
| rd_peer_i | input | 1 | Read strobe for the partner capture register |
| count_o | output | TS_W | Current timestamp |
| local_ts_o | output | TS_W | Value captured on the local trigger |
| local_vld_o | output | 1 | Local capture valid |
| local_ovr_o | output | 1 | Local capture overrun |
| peer_ts_o | output | TS_W | Value captured on the partner trigger |
| peer_vld_o | output | 1 | Partner capture valid |
| peer_ovr_o | output | 1 | Partner capture overrun |
| peer_rst_o | output | 1 | Reset pulse to the partner system |
| clk2x_o | output | 1 | Square wave at twice the tick rate |

## Verification
The assertions take the following for granted:
- Each asynchronous input stays high for at least one full clock cycle, so the synchronizer sees it.
- run_start_i and the read strobes are synchronous, and each lasts a whole cycle.

The stimulus meets these by changing every input on the falling clock edge. Each pulse is held across at least one rising edge. Latency checks count edges from that point: the synchronized inputs take effect SYNC_STAGES edges later, and the run-start command takes effect on the very next edge.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

   typedef enum logic {
      PULSE_IDLE,
      PULSE_BUSY
   } pulse_state_e;

   // Order of the synchronized inputs; the capture channels come first so
   // that their index also selects the capture register.
   localparam int unsigned CH_LOCAL  = 0;
   localparam int unsigned CH_PEER   = 1;
   localparam int unsigned CH_EXTRST = 2;
   localparam int unsigned NUM_SYNC  = 3;
   localparam int unsigned NUM_LATCH = 2;

endpackage

// File: rtl/tsc_edge_sync.sv
module tsc_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tsc_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         last_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], async_i};
         last_q <= sh_q[STAGES-1];
      end
   end

   assign rise_o = sh_q[STAGES-1] & ~last_q;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R2

endmodule

// File: rtl/tsc_timebase.sv
module tsc_timebase #(
   parameter int unsigned REF_DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   output logic tick_o,
   output logic clk2x_o
);

   localparam int unsigned PW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
   localparam int unsigned Q  = REF_DIV / 4;

   if (REF_DIV < 4 || (REF_DIV % 4) != 0) begin : g_bad_div
      $error("tsc_timebase: REF_DIV must be a multiple of 4, at least 4");
   end

   logic [PW-1:0] pre_q;
   logic          wrap;
   logic          toggle_en;
   logic          wave_q;

   assign wrap = (pre_q == PW'(REF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (clear_i || wrap) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   assign tick_o = wrap & ~clear_i;

   if (Q == 1) begin : g_toggle_every
      assign toggle_en = 1'b1;
   end else begin : g_toggle_div
      localparam int unsigned QW = $clog2(Q);
      logic [QW-1:0] sub_q;
      logic          sub_wrap;

      assign sub_wrap = (sub_q == QW'(Q - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sub_q <= '0;
         end else if (clear_i || sub_wrap) begin
            sub_q <= '0;
         end else begin
            sub_q <= sub_q + 1'b1;
         end
      end

      assign toggle_en = sub_wrap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wave_q <= 1'b0;
      end else if (clear_i) begin
         wave_q <= 1'b0;
      end else if (toggle_en) begin
         wave_q <= ~wave_q;
      end
   end

   assign clk2x_o = wave_q;

   AST_WAVE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> clk2x_o); // R9

   AST_WAVE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !clk2x_o); // R9

endmodule

// File: rtl/tsc_latch.sv
module tsc_latch #(
   parameter int unsigned W = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap_i,
   input  logic         rd_i,
   input  logic [W-1:0] value_i,
   output logic [W-1:0] data_o,
   output logic         vld_o,
   output logic         ovr_o
);

   if (W < 1) begin : g_bad_w
      $error("tsc_latch: W must be positive");
   end

   logic [W-1:0] data_q;
   logic         vld_q;
   logic         ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (cap_i) begin
         data_q <= value_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         ovr_q <= 1'b0;
      end else begin
         if (cap_i) begin
            vld_q <= 1'b1;
         end else if (rd_i) begin
            vld_q <= 1'b0;
         end
         if (cap_i && vld_q && !rd_i) begin
            ovr_q <= 1'b1;
         end else if (rd_i) begin
            ovr_q <= 1'b0;
         end
      end
   end

   assign data_o = data_q;
   assign vld_o  = vld_q;
   assign ovr_o  = ovr_q;

   AST_VLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> vld_o); // R5

   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_i && vld_o && !rd_i) |=> ovr_o); // R6

   AST_OVR_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_o |-> vld_o); // R6

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_i |=> $stable(data_o)); // R3

endmodule

// File: rtl/tsc_pulse.sv
module tsc_pulse import tsc_pkg::*; #(
   parameter int unsigned CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic pulse_o
);

   localparam int unsigned CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("tsc_pulse: CYCLES must be at least 1");
   end

   pulse_state_e state_q;
   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PULSE_IDLE;
         left_q  <= '0;
      end else if (fire_i) begin
         state_q <= PULSE_BUSY;
         left_q  <= CW'(CYCLES - 1);
      end else if (state_q == PULSE_BUSY) begin
         if (left_q == '0) begin
            state_q <= PULSE_IDLE;
         end else begin
            left_q <= left_q - 1'b1;
         end
      end
   end

   assign pulse_o = (state_q == PULSE_BUSY);

   AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> pulse_o); // R8

endmodule

// File: rtl/tsc_sync_core.sv
module tsc_sync_core import tsc_pkg::*; #(
   parameter int unsigned TS_W        = 48,
   parameter int unsigned REF_DIV     = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RST_CYCLES  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trig_local_i,
   input  logic            trig_peer_i,
   input  logic            ts_rst_i,
   input  logic            ext_rst_en_i,
   input  logic            run_start_i,
   input  logic            rd_local_i,
   input  logic            rd_peer_i,
   output logic [TS_W-1:0] count_o,
   output logic [TS_W-1:0] local_ts_o,
   output logic            local_vld_o,
   output logic            local_ovr_o,
   output logic [TS_W-1:0] peer_ts_o,
   output logic            peer_vld_o,
   output logic            peer_ovr_o,
   output logic            peer_rst_o,
   output logic            clk2x_o
);

   if (TS_W < 2) begin : g_bad_tsw
      $error("tsc_sync_core: TS_W must be at least 2");
   end

   // input synchronizers
   logic [NUM_SYNC-1:0] async_in;
   logic [NUM_SYNC-1:0] rise;

   assign async_in[CH_LOCAL]  = trig_local_i;
   assign async_in[CH_PEER]   = trig_peer_i;
   assign async_in[CH_EXTRST] = ts_rst_i;

   for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
      tsc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_i (async_in[g]),
         .rise_o  (rise[g])
      );
   end

   // clear sources
   logic ext_clear;
   logic clear;

   assign ext_clear = rise[CH_EXTRST] & ext_rst_en_i;
   assign clear     = ext_clear | run_start_i;

   // reference tick and exported wave
   logic tick;

   tsc_timebase #(.REF_DIV(REF_DIV)) u_timebase (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .tick_o  (tick),
      .clk2x_o (clk2x_o)
   );

   // timestamp counter
   logic [TS_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (clear) begin
         count_q <= '0;
      end else if (tick) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign count_o = count_q;

   // capture registers
   logic [TS_W-1:0]      lat_data [NUM_LATCH];
   logic [NUM_LATCH-1:0] lat_vld;
   logic [NUM_LATCH-1:0] lat_ovr;
   logic [NUM_LATCH-1:0] lat_rd;

   assign lat_rd[CH_LOCAL] = rd_local_i;
   assign lat_rd[CH_PEER]  = rd_peer_i;

   for (genvar g = 0; g < NUM_LATCH; g++) begin : g_latch
      tsc_latch #(.W(TS_W)) u_latch (
         .clk     (clk),
         .rst_n   (rst_n),
         .cap_i   (rise[g]),
         .rd_i    (lat_rd[g]),
         .value_i (count_q),
         .data_o  (lat_data[g]),
         .vld_o   (lat_vld[g]),
         .ovr_o   (lat_ovr[g])
      );
   end

   assign local_ts_o  = lat_data[CH_LOCAL];
   assign local_vld_o = lat_vld[CH_LOCAL];
   assign local_ovr_o = lat_ovr[CH_LOCAL];
   assign peer_ts_o   = lat_data[CH_PEER];
   assign peer_vld_o  = lat_vld[CH_PEER];
   assign peer_ovr_o  = lat_ovr[CH_PEER];

   // reset pulse for the partner system
   tsc_pulse #(.CYCLES(RST_CYCLES)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (run_start_i),
      .pulse_o (peer_rst_o)
   );

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (count_q == $past(count_q) ||
                  count_q == $past(count_q) + TS_W'(1))); // R1

   AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count_q == '0)); // R7

   AST_PULSE_WITH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(peer_rst_o) |-> (count_q == '0)); // R8

endmodule

// File: tb/tsc_sync_core_bench.sv
module tsc_sync_core_bench;

   localparam int unsigned TS_W = 8;
   localparam int unsigned DIV  = 4;
   localparam int unsigned SYNC = 2;
   localparam int unsigned RSTC = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            trig_local = 1'b0;
   logic            trig_peer = 1'b0;
   logic            ts_rst = 1'b0;
   logic            ext_rst_en = 1'b1;
   logic            run_start = 1'b0;
   logic            rd_local = 1'b0;
   logic            rd_peer = 1'b0;
   logic [TS_W-1:0] count;
   logic [TS_W-1:0] local_ts;
   logic            local_vld;
   logic            local_ovr;
   logic [TS_W-1:0] peer_ts;
   logic            peer_vld;
   logic            peer_ovr;
   logic            peer_rst;
   logic            clk2x;

   int n_chk = 0;
   int n_bad = 0;
   int m = 0;

   always #2 clk = ~clk;

   tsc_sync_core #(
      .TS_W(TS_W), .REF_DIV(DIV), .SYNC_STAGES(SYNC), .RST_CYCLES(RSTC)
   ) u_tsc_sync_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .trig_local_i (trig_local),
      .trig_peer_i  (trig_peer),
      .ts_rst_i     (ts_rst),
      .ext_rst_en_i (ext_rst_en),
      .run_start_i  (run_start),
      .rd_local_i   (rd_local),
      .rd_peer_i    (rd_peer),
      .count_o      (count),
      .local_ts_o   (local_ts),
      .local_vld_o  (local_vld),
      .local_ovr_o  (local_ovr),
      .peer_ts_o    (peer_ts),
      .peer_vld_o   (peer_vld),
      .peer_ovr_o   (peer_ovr),
      .peer_rst_o   (peer_rst),
      .clk2x_o      (clk2x)
   );

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // advance n falling edges, tracking cycles since the last clear
   task automatic nw(input int n);
      repeat (n) begin
         @(negedge clk);
         m++;
      end
   endtask

   // expected counter value for a value captured from a trigger raised at m=M
   function automatic longint cap_val(input int mm);
      return longint'(((mm + 2) / DIV) % (1 << TS_W));
   endfunction

   task automatic do_run_start();
      @(negedge clk);
      run_start = 1'b1;
      @(negedge clk);
      run_start = 1'b0;
      m = 0;
   endtask

   task automatic pulse_local();
      trig_local = 1'b1;
      nw(1);
      trig_local = 1'b0;
      nw(2);
   endtask

   task automatic read_local();
      rd_local = 1'b1;
      nw(1);
      rd_local = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10", "count", count, 0);
      chk("R10", "local_vld", local_vld, 0);
      chk("R10", "peer_vld", peer_vld, 0);
      chk("R10", "local_ovr", local_ovr, 0);
      chk("R10", "peer_rst", peer_rst, 0);
      chk("R10", "clk2x", clk2x, 0);
      chk("R10", "local_ts", local_ts, 0);
      rst_n = 1'b1;
      nw(2);
   endtask

   task automatic t_run_start();
      nw(5);
      do_run_start();
      chk("R8", "peer_rst at clear edge", peer_rst, 1);
      chk("R8", "count at clear edge", count, 0);
      for (int k = 1; k < RSTC; k++) begin
         nw(1);
         chk("R8", "peer_rst held", peer_rst, 1);
      end
      nw(1);
      chk("R8", "peer_rst ended", peer_rst, 0);
      chk("R1", "count after one period", count, 1);
      nw(3);
      chk("R1", "count m=7", count, 1);
      nw(1);
      chk("R1", "count m=8", count, 2);
   endtask

   task automatic t_wave();
      int rises;
      logic prev;
      do_run_start();
      rises = 0;
      prev  = clk2x;
      chk("R9", "wave low after clear", clk2x, 0);
      for (int i = 1; i < 16; i++) begin
         nw(1);
         chk("R9", "wave phase", clk2x, (i / (DIV / 4)) % 2);
         if (clk2x && !prev) rises++;
         prev = clk2x;
      end
      chk("R9", "rises in 15 cycles", rises, 8);
   endtask

   task automatic t_local_peer();
      do_run_start();
      nw(9);
      trig_local = 1'b1;
      nw(1);
      trig_local = 1'b0;
      nw(1);
      chk("R2", "local_vld before sync latency", local_vld, 0);
      nw(1);
      chk("R2", "local_vld after sync latency", local_vld, 1);
      chk("R3", "local_ts", local_ts, cap_val(9));
      chk("R4", "peer_vld untouched", peer_vld, 0);
      trig_peer = 1'b1;
      nw(1);
      trig_peer = 1'b0;
      nw(2);
      chk("R4", "peer_ts", peer_ts, cap_val(12));
      chk("R4", "peer_vld", peer_vld, 1);
      chk("R4", "local_ts unchanged", local_ts, cap_val(9));
      chk("R4", "local_ovr unchanged", local_ovr, 0);
   endtask

   task automatic t_read();
      read_local();
      chk("R5", "local_vld after read", local_vld, 0);
      chk("R5", "peer_vld kept", peer_vld, 1);
      rd_peer = 1'b1;
      nw(1);
      rd_peer = 1'b0;
      chk("R5", "peer_vld after read", peer_vld, 0);
   endtask

   task automatic t_overrun();
      int mm;
      pulse_local();
      nw(5);
      mm = m;
      pulse_local();
      chk("R6", "overrun set", local_ovr, 1);
      chk("R6", "valid kept", local_vld, 1);
      chk("R6", "newest data kept", local_ts, cap_val(mm));
      read_local();
      chk("R6", "overrun cleared by read", local_ovr, 0);
      chk("R6", "valid cleared by read", local_vld, 0);
   endtask

   task automatic t_read_and_capture();
      int mm;
      pulse_local();
      nw(2);
      mm = m;
      trig_local = 1'b1;
      nw(1);
      trig_local = 1'b0;
      nw(1);
      rd_local = 1'b1;
      nw(1);
      rd_local = 1'b0;
      chk("R5", "valid with read+capture", local_vld, 1);
      chk("R5", "no overrun with read+capture", local_ovr, 0);
      chk("R5", "data with read+capture", local_ts, cap_val(mm));
      read_local();
   endtask

   task automatic t_held();
      trig_local = 1'b1;
      nw(3);
      chk("R2", "held input captured", local_vld, 1);
      read_local();
      nw(20);
      chk("R2", "held input no recapture", local_vld, 0);
      chk("R2", "held input no overrun", local_ovr, 0);
      trig_local = 1'b0;
      nw(4);
      chk("R2", "falling edge ignored", local_vld, 0);
   endtask

   task automatic t_ext_reset();
      int mm;
      do_run_start();
      nw(10);
      ext_rst_en = 1'b1;
      mm = m;
      ts_rst = 1'b1;
      nw(1);
      ts_rst = 1'b0;
      nw(1);
      chk("R7", "count before ext clear", count, ((mm + 2) / DIV) % (1 << TS_W));
      nw(1);
      chk("R7", "count after ext clear", count, 0);
      chk("R7", "wave after ext clear", clk2x, 0);
      chk("R7", "no partner pulse from ext reset", peer_rst, 0);
      m = 0;
      nw(4);
      chk("R7", "counting restarts", count, 1);
      nw(8);
      ext_rst_en = 1'b0;
      mm = m;
      ts_rst = 1'b1;
      nw(1);
      ts_rst = 1'b0;
      nw(2);
      chk("R7", "disabled ext reset ignored", count, ((mm + 3) / DIV) % (1 << TS_W));
      ext_rst_en = 1'b1;
   endtask

   task automatic t_wrap();
      do_run_start();
      nw(DIV * (1 << TS_W) - 1);
      chk("R1", "count at top", count, (1 << TS_W) - 1);
      nw(1);
      chk("R1", "count wrapped", count, 0);
      nw(DIV);
      chk("R1", "count after wrap", count, 1);
   endtask

   logic done = 1'b0;

   initial begin
      t_reset();
      t_run_start();
      t_wave();
      t_local_peer();
      t_read();
      t_overrun();
      t_read_and_capture();
      t_held();
      t_ext_reset();
      t_wrap();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog run did not complete actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule